// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Emulator

This block is a synthesizable, clocked stand-in for a 16-bit-wide asynchronous static RAM with two independently enabled byte lanes. Once per clock it samples five active-low controls: select, output enable, write enable, and one enable for each byte lane. From them it decodes, per lane, whether that lane is being read, being written, or left undriven. It also produces one overall mode code.

Read data and the per-lane drive enables leave the block as registered signals, so a top level can build a bidirectional pad from them. Writes behave as they do on an asynchronous part. A lane's write stays open while select, write enable and that lane's enable are all low. The word is stored only when the write closes, using the address and data seen in the last sampled cycle of the open write. A read that comes right after the closing cycle returns the new bytes.

The array is sized by `ADDR_W`. `ADDR_W = 15` gives the full 32,768-word part. The default of 10 keeps elaboration small.

Top module: `sram_lane_emu`

## Requirements
- R1: The array holds 2^ADDR_W words of LANES byte lanes of LANE_W bits each, with lane i on data bits [8i+7:8i]. Every address from 0 to 2^ADDR_W-1, including the top one, stores and returns its own word.
- R2: A cycle sampled with `sel_n` high produces `mode` = 0 and `dq_oe` = 0 on the next cycle, whatever the other controls are.
- R3: A cycle sampled with `sel_n` low, `rd_en_n` low and `wr_en_n` high sets `dq_oe[i]` to the inverse of `lane_en_n[i]` on the next cycle. Each enabled lane then shows that address's stored byte on `dq_out`.
- R4: A write stores lane i only if `lane_en_n[i]` is low. A lane whose enable is high keeps its old byte, and the state of `rd_en_n` has no effect on the write.
- R5: `dq_oe` is all zero on the cycle after any sample in which `rd_en_n` is high, or both lane enables are high, or `sel_n` and `wr_en_n` are both low.
- R6: A lane's write is open only while `sel_n`, `wr_en_n` and that lane's enable are all low. When any of the three is sampled high, the write closes and the lane commits. With both lane enables high, nothing is stored.
- R7: The byte committed is the data and address from the last sampled cycle of the open write, not the first one. The lanes open and close independently.
- R8: `mode` encodes 0 for deselected and 3 for a write (`sel_n` low, `wr_en_n` low, at least one lane enable low). It encodes 2 for a read (`sel_n` low, `rd_en_n` low, `wr_en_n` high, at least one lane enable low) and 1 for selected with outputs off. It is registered like the data.
- R9: A read sampled in the same cycle that a write to that address closes returns the newly written bytes.
- R10: Reset clears `dq_oe` and `mode` to 0 and drops any open write. `dq_out` lane bits are 0 whenever that lane's enable is 0. Array contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low chip select |
| rd_en_n | input | 1 | Active-low output enable |
| wr_en_n | input | 1 | Active-low write enable |
| lane_en_n | input | LANES | Active-low per-lane enables, bit i for lane i |
| addr | input | ADDR_W | Word address |
| dq_in | input | LANES*LANE_W | Write data, lane i on bits [8i+7:8i] |
| dq_out | output | LANES*LANE_W | Registered read data, zero on undriven lanes |
| dq_oe | output | LANES | Registered per-lane drive enable |
| mode | output | 2 | Registered mode code (0 off, 1 idle, 2 read, 3 write) |

## Verification
The hardest situation to reach from the ports is a write whose two lanes close on different cycles. The upper lane must commit its early data while the lower lane stays open and keeps taking new bytes. The bench builds this by holding select and write enable low and raising only the upper lane enable mid-write. It then changes the data and the address before closing the lower lane, and reads both lanes back. It also places a read directly after a closing write cycle, so that the commit and the read fall on the same edge.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_READ  = 2'd2,
    MODE_WRITE = 2'd3
  } sram_mode_e;

  // a lane's write is open while all three of its controls are low
  function automatic logic lane_write_open(input logic sel_n, input logic wr_n,
                                           input logic lane_n);
    return (!sel_n) && (!wr_n) && (!lane_n);
  endfunction

  // a lane drives data only for a selected, output-enabled, non-write cycle
  function automatic logic lane_read_on(input logic sel_n, input logic oe_n,
                                        input logic wr_n, input logic lane_n);
    return (!sel_n) && (!oe_n) && wr_n && (!lane_n);
  endfunction

  function automatic sram_mode_e mode_of(input logic sel_n, input logic oe_n,
                                         input logic wr_n, input logic any_lane);
    sram_mode_e m;
    if (sel_n)                        m = MODE_OFF;
    else if (!wr_n && any_lane)       m = MODE_WRITE;
    else if (!oe_n && wr_n && any_lane) m = MODE_READ;
    else                              m = MODE_IDLE;
    return m;
  endfunction

endpackage

// File: rtl/sram_ctl_decode.sv
module sram_ctl_decode
  import sram_emu_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             sel_n,
  input  logic             rd_en_n,
  input  logic             wr_en_n,
  input  logic [LANES-1:0] lane_en_n,
  output logic [LANES-1:0] wr_open,
  output logic [LANES-1:0] rd_on,
  output sram_mode_e       mode_nx
);

  logic any_lane;

  assign any_lane = ~&lane_en_n;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign wr_open[i] = lane_write_open(sel_n, wr_en_n, lane_en_n[i]);
    assign rd_on[i]   = lane_read_on(sel_n, rd_en_n, wr_en_n, lane_en_n[i]);
  end

  assign mode_nx = mode_of(sel_n, rd_en_n, wr_en_n, any_lane);

endmodule

// File: rtl/sram_byte_lane.sv
module sram_byte_lane #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_open,
  input  logic              rd_on,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] din,
  output logic [LANE_W-1:0] q,
  output logic              q_en,
  output logic              commit,
  output logic              pend
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] store [DEPTH];
  logic              pend_q;
  logic [ADDR_W-1:0] pend_a;
  logic [LANE_W-1:0] pend_d;
  logic [LANE_W-1:0] rd_word;
  logic              hit;

  // write closes: the held address and byte go to the array this edge
  assign commit = pend_q && !wr_open;
  assign pend   = pend_q;
  assign hit    = commit && (pend_a == addr);
  assign rd_word = hit ? pend_d : store[addr];

  always_ff @(posedge clk) begin
    if (commit) store[pend_a] <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pend_a <= '0;
      pend_d <= '0;
    end else if (wr_open) begin
      pend_q <= 1'b1;
      pend_a <= addr;
      pend_d <= din;
    end else begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q    <= '0;
      q_en <= 1'b0;
    end else begin
      q_en <= rd_on;
      q    <= rd_on ? rd_word : '0;
    end
  end

endmodule

// File: rtl/sram_lane_emu.sv
module sram_lane_emu
  import sram_emu_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel_n,
  input  logic                    rd_en_n,
  input  logic                    wr_en_n,
  input  logic [LANES-1:0]        lane_en_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic [LANES-1:0]        dq_oe,
  output logic [1:0]              mode
);

  logic [LANES-1:0] lane_wr_open;
  logic [LANES-1:0] lane_rd_on;
  logic [LANES-1:0] lane_commit;
  logic [LANES-1:0] lane_pend;
  sram_mode_e       mode_nx;
  sram_mode_e       mode_q;

  sram_ctl_decode #(.LANES(LANES)) u_dec (
    .sel_n     (sel_n),
    .rd_en_n   (rd_en_n),
    .wr_en_n   (wr_en_n),
    .lane_en_n (lane_en_n),
    .wr_open   (lane_wr_open),
    .rd_on     (lane_rd_on),
    .mode_nx   (mode_nx)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    sram_byte_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_open (lane_wr_open[i]),
      .rd_on   (lane_rd_on[i]),
      .addr    (addr),
      .din     (dq_in[i*LANE_W +: LANE_W]),
      .q       (dq_out[i*LANE_W +: LANE_W]),
      .q_en    (dq_oe[i]),
      .commit  (lane_commit[i]),
      .pend    (lane_pend[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_OFF;
    else        mode_q <= mode_nx;
  end

  assign mode = mode_q;

endmodule

// File: rtl/sram_emu_chk.sv
module sram_emu_chk #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sel_n,
  input logic                    rd_en_n,
  input logic                    wr_en_n,
  input logic [LANES-1:0]        lane_en_n,
  input logic [ADDR_W-1:0]       addr,
  input logic [LANES*LANE_W-1:0] dq_out,
  input logic [LANES-1:0]        dq_oe,
  input logic [1:0]              mode,
  input logic [LANES-1:0]        lane_commit,
  input logic [LANES-1:0]        lane_pend
);

  assert_deselect_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> (mode == 2'd0 && dq_oe == '0));

  assert_write_no_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !wr_en_n) |=> (dq_oe == '0));

  assert_oe_off_no_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_n |=> (dq_oe == '0));

  assert_read_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !rd_en_n && wr_en_n) |=> (dq_oe == ~$past(lane_en_n)));

  assert_read_mode_drives_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> (dq_oe != '0));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assert_commit_on_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lane_commit[i] |-> (lane_pend[i] && (sel_n || wr_en_n || lane_en_n[i])));

    assert_idle_lane_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_oe[i] |-> (dq_out[i*LANE_W +: LANE_W] == '0));
  end

endmodule

bind sram_lane_emu sram_emu_chk #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sel_n       (sel_n),
  .rd_en_n     (rd_en_n),
  .wr_en_n     (wr_en_n),
  .lane_en_n   (lane_en_n),
  .addr        (addr),
  .dq_out      (dq_out),
  .dq_oe       (dq_oe),
  .mode        (mode),
  .lane_commit (lane_commit),
  .lane_pend   (lane_pend)
);

// File: tb/sim_sram_lane_emu.sv
module sim_sram_lane_emu;

  localparam int AW = 10;
  localparam int NW = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1;
  logic        rd_en_n = 1'b1;
  logic        wr_en_n = 1'b1;
  logic [1:0]  lane_en_n = 2'b11;
  logic [AW-1:0] addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic [1:0]  dq_oe;
  logic [1:0]  mode;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // behavioural reference state
  logic [7:0]    ref_mem [0:1][0:NW-1];
  bit            rp [0:1];
  int            ra [0:1];
  logic [7:0]    rd [0:1];

  always #5 clk = ~clk;

  sram_lane_emu u0 (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_en_n(rd_en_n),
    .wr_en_n(wr_en_n), .lane_en_n(lane_en_n), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .mode(mode)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one sampled cycle: drive, model the edge, compare after it
  task automatic step(input logic c, input logic o, input logic w,
                      input logic [1:0] b, input int a, input logic [15:0] d,
                      input string tag);
    logic [1:0]  e_oe;
    logic [15:0] e_q;
    logic [1:0]  e_mode;
    bit rdc;
    @(negedge clk);
    sel_n = c; rd_en_n = o; wr_en_n = w; lane_en_n = b; addr = AW'(a); dq_in = d;
    @(posedge clk);
    rdc = !c && !o && w;
    e_q = '0;
    for (int l = 0; l < 2; l++) begin
      bit wact;
      bit cm;
      wact = !c && !w && !b[l];
      cm = rp[l] && !wact;
      e_oe[l] = rdc && !b[l];
      if (e_oe[l]) e_q[l*8 +: 8] = (cm && ra[l] == a) ? rd[l] : ref_mem[l][a];
      if (cm) begin ref_mem[l][ra[l]] = rd[l]; rp[l] = 1'b0; end
      if (wact) begin rp[l] = 1'b1; ra[l] = a; rd[l] = d[l*8 +: 8]; end
    end
    if (c) e_mode = 2'd0;
    else if (!w && b != 2'b11) e_mode = 2'd3;
    else if (!o && w && b != 2'b11) e_mode = 2'd2;
    else e_mode = 2'd1;
    #1;
    check(dq_oe == e_oe, tag, "dq_oe", {14'd0, dq_oe}, {14'd0, e_oe});
    check(mode == e_mode, "R8", "mode", {14'd0, mode}, {14'd0, e_mode});
    check(dq_out == e_q, tag, "dq_out", dq_out, e_q);
  endtask

  task automatic wr_word(input int a, input logic [15:0] d, input logic [1:0] b,
                         input string tag);
    step(1'b0, 1'b1, 1'b0, b, a, d, tag);
    step(1'b1, 1'b1, 1'b1, 2'b11, a, 16'h0, tag);
  endtask

  task automatic rd_word(input int a, input logic [1:0] b, input string tag);
    step(1'b0, 1'b0, 1'b1, b, a, 16'h0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rp[0] = 0; rp[1] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state
    check(dq_oe == 2'b00, "R10", "reset dq_oe", {14'd0, dq_oe}, 16'h0);
    check(mode == 2'd0, "R10", "reset mode", {14'd0, mode}, 16'h0);
    check(dq_out == 16'h0, "R10", "reset dq_out", dq_out, 16'h0);

    // fill low addresses, then the top one (R1)
    for (int i = 0; i < 16; i++) wr_word(i, 16'hA500 + 16'(i * 17), 2'b00, "R4");
    wr_word(NW - 1, 16'hBEEF, 2'b00, "R1");
    for (int i = 0; i < 16; i++) rd_word(i, 2'b00, "R3");
    rd_word(NW - 1, 2'b00, "R1");

    // lane-only writes and lane-only reads (R4, R3)
    wr_word(3, 16'h1177, 2'b10, "R4");
    wr_word(4, 16'h22CC, 2'b01, "R4");
    rd_word(3, 2'b00, "R4");
    rd_word(4, 2'b10, "R3");
    rd_word(4, 2'b01, "R3");

    // write with output enable low still writes (R4)
    step(1'b0, 1'b0, 1'b0, 2'b00, 5, 16'h5A5A, "R4");
    step(1'b0, 1'b0, 1'b1, 2'b00, 5, 16'h0, "R9");

    // outputs-off cases (R5) and deselect (R2)
    step(1'b0, 1'b1, 1'b1, 2'b00, 5, 16'h0, "R5");
    step(1'b0, 1'b0, 1'b1, 2'b11, 5, 16'h0, "R5");
    step(1'b1, 1'b0, 1'b1, 2'b00, 5, 16'h0, "R2");
    step(1'b1, 1'b0, 1'b0, 2'b00, 6, 16'hFFFF, "R2");
    rd_word(6, 2'b00, "R2");

    // both lane enables high during write: nothing stored (R6)
    step(1'b0, 1'b1, 1'b0, 2'b11, 7, 16'hDEAD, "R6");
    rd_word(7, 2'b00, "R6");

    // long write, data changes, closed by write enable (R7)
    step(1'b0, 1'b1, 1'b0, 2'b00, 8, 16'h1111, "R7");
    step(1'b0, 1'b1, 1'b0, 2'b00, 8, 16'h2222, "R7");
    step(1'b0, 1'b1, 1'b0, 2'b00, 8, 16'h3333, "R7");
    rd_word(8, 2'b00, "R9");
    // closed by select going high (R6)
    step(1'b0, 1'b1, 1'b0, 2'b00, 9, 16'h4444, "R6");
    step(1'b1, 1'b1, 1'b0, 2'b00, 9, 16'h9999, "R6");
    rd_word(9, 2'b00, "R6");

    // split close: upper lane ends early, lower continues at a new address (R7)
    step(1'b0, 1'b1, 1'b0, 2'b00, 10, 16'hAB01, "R7");
    step(1'b0, 1'b1, 1'b0, 2'b10, 10, 16'hCD02, "R7");
    step(1'b0, 1'b1, 1'b0, 2'b10, 11, 16'hEF03, "R7");
    step(1'b0, 1'b1, 1'b1, 2'b10, 11, 16'h0, "R7");
    rd_word(10, 2'b00, "R7");
    rd_word(11, 2'b00, "R7");

    // mixed random traffic over initialized words
    for (int n = 0; n < 400; n++) begin
      logic [3:0] r;
      r = 4'($urandom);
      step(r == 4'd0, 1'($urandom), (r < 4'd6) ? 1'b0 : 1'b1, 2'($urandom),
           int'($urandom % 16), 16'($urandom), "R9");
    end
    step(1'b1, 1'b1, 1'b1, 2'b11, 0, 16'h0, "R6");
    for (int i = 0; i < 16; i++) rd_word(i, 2'b00, "R3");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule